// File: doc/BRIEF.md
# Modem Handshake Line Controller

This block looks after the handshake lines of a 16550-style serial port. A six-bit control value from the register file drives four active-low outputs (data-terminal-ready, request-to-send and two general-purpose outputs). Four active-low inputs (clear-to-send, data-set-ready, ring indicator and carrier detect) are synchronised and presented as an eight-bit status byte. The byte holds the current asserted level of each line and a sticky change flag for each line. The flags clear when software reads the byte. Any set flag raises a modem interrupt request.

Two modes change the data path. Internal loopback feeds the block's own outputs back into its status inputs and parks the external outputs at their inactive level. Automatic flow control withdraws request-to-send while the receive FIFO is at or above its trigger level. It also lets the transmitter start a character only while clear-to-send is asserted.

Top module: `modem_line_unit`

## Requirements
- R1: While reset is held, the four output pins are high (inactive), the status byte is 0x00, the interrupt request is low, and with control bit 5 low the transmit permit is high.
- R2: With control bit 4 low, one clock after a control value is applied, dtr_out_n equals the inverse of bit 0, rts_out_n the inverse of bit 1, out1_out_n the inverse of bit 2 and out2_out_n the inverse of bit 3.
- R3: Status bits 4, 5, 6 and 7 read 1 when the clear-to-send, data-set-ready, ring and carrier-detect pins respectively are low. A pin change shows there SYNC_STAGES+1 clocks after it is applied.
- R4: Status bits 0, 1 and 3 set on any change of status bit 4, 5 and 7 respectively, in the same clock that the level bit changes.
- R5: Status bit 2 sets only when status bit 6 falls from 1 to 0 (the ring pin returning high), never when it rises.
- R6: Change flags stay set until a clock edge during which stat_rd is high, and clear at that edge. A change that lands on that same edge leaves its flag set.
- R7: irq_modem is high exactly when any of status bits 0 to 3 is set.
- R8: With control bit 4 high, all four output pins are high one clock later. The status inputs then come from the control bits: clear-to-send from the effective request-to-send, data-set-ready from bit 0, ring from bit 2 and carrier detect from bit 3. This takes one clock, and the external input pins are ignored.
- R9: With control bit 5 high and rx_near_full high, the effective request-to-send is off whatever bit 1 holds: rts_out_n reads high one clock later, and in loopback status bit 4 clears.
- R10: tx_permit is high while control bit 5 is low. While bit 5 is high, tx_permit equals status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_bits | input | 6 | Control value: 0 DTR, 1 RTS, 2 OUT1, 3 OUT2, 4 loopback, 5 auto flow control |
| stat_rd | input | 1 | Status read strobe; clears change flags at the edge |
| stat_byte | output | 8 | Levels in bits 7..4, change flags in bits 3..0 |
| cts_in_n | input | 1 | Clear-to-send pin, active low |
| dsr_in_n | input | 1 | Data-set-ready pin, active low |
| ri_in_n | input | 1 | Ring indicator pin, active low |
| dcd_in_n | input | 1 | Carrier detect pin, active low |
| dtr_out_n | output | 1 | Data-terminal-ready pin, active low |
| rts_out_n | output | 1 | Request-to-send pin, active low |
| out1_out_n | output | 1 | General output 1, active low |
| out2_out_n | output | 1 | General output 2, active low |
| rx_near_full | input | 1 | Receive FIFO at or above its trigger level |
| tx_permit | output | 1 | Transmitter may start a character |
| irq_modem | output | 1 | Modem status interrupt request |

## Verification
The output pins follow the control value one clock later. Status levels and change flags move together, SYNC_STAGES+1 clocks after an external pin changes, or one clock after a control change in loopback. A read strobe takes effect at the edge it spans. The interrupt request and the transmit permit are combinational from those registers and the current control value. The bench reference model applies each of these latencies at every rising edge, from the inputs present at that edge. All outputs are compared at the following falling edge, so every result is checked in the exact cycle it is due. Inputs change only just after a falling edge.

// File: rtl/mlu_pkg.sv
package mlu_pkg;
   localparam int CTL_W   = 6;
   localparam int LN      = 4;
   localparam int STAT_W  = 2 * LN;

   // control bit positions (decoded by the register file)
   localparam int CB_DTR  = 0;
   localparam int CB_RTS  = 1;
   localparam int CB_OUT1 = 2;
   localparam int CB_OUT2 = 3;
   localparam int CB_LOOP = 4;
   localparam int CB_AFC  = 5;

   // status line order (levels at LN+idx, flags at idx)
   localparam int IDX_CTS = 0;
   localparam int IDX_DSR = 1;
   localparam int IDX_RI  = 2;
   localparam int IDX_DCD = 3;

   // output drive order
   localparam int DRV_DTR  = 0;
   localparam int DRV_RTS  = 1;
   localparam int DRV_OUT1 = 2;
   localparam int DRV_OUT2 = 3;

   typedef logic [LN-1:0] line_vec_t;
endpackage

// File: rtl/mlu_sync.sv
module mlu_sync #(
   parameter int              W       = 4,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/mlu_drive.sv
module mlu_drive
   import mlu_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CTL_W-1:0] ctl,
   input  logic             rx_near_full,
   output logic [LN-1:0]    drv_n,
   output line_vec_t        loop_src
);
   logic          rts_eff;
   logic [LN-1:0] want;

   // flow control withdraws request-to-send while the FIFO is nearly full
   assign rts_eff = ctl[CB_RTS] & ~(ctl[CB_AFC] & rx_near_full);

   always_comb begin
      want           = '0;
      want[DRV_DTR]  = ctl[CB_DTR];
      want[DRV_RTS]  = rts_eff;
      want[DRV_OUT1] = ctl[CB_OUT1];
      want[DRV_OUT2] = ctl[CB_OUT2];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             drv_n <= '1;
      else if (ctl[CB_LOOP])  drv_n <= '1;
      else                    drv_n <= ~want;
   end

   always_comb begin
      loop_src          = '0;
      loop_src[IDX_CTS] = rts_eff;
      loop_src[IDX_DSR] = ctl[CB_DTR];
      loop_src[IDX_RI]  = ctl[CB_OUT1];
      loop_src[IDX_DCD] = ctl[CB_OUT2];
   end
endmodule

// File: rtl/mlu_delta.sv
module mlu_delta
   import mlu_pkg::*;
#(
   parameter bit RI_TRAIL_ONLY = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  line_vec_t cur,
   input  logic      clr,
   output line_vec_t lines_q,
   output line_vec_t delta_q
);
   line_vec_t chg;

   for (genvar b = 0; b < LN; b++) begin : g_edge
      if (RI_TRAIL_ONLY && b == IDX_RI) begin : g_trail
         assign chg[b] = lines_q[b] & ~cur[b];
      end else begin : g_any
         assign chg[b] = lines_q[b] ^ cur[b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lines_q <= '0;
         delta_q <= '0;
      end else begin
         lines_q <= cur;
         // a new event wins over a clear on the same edge
         delta_q <= (clr ? '0 : delta_q) | chg;
      end
   end
endmodule

// File: rtl/modem_line_unit.sv
module modem_line_unit
   import mlu_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter bit RI_TRAIL_ONLY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CTL_W-1:0] ctl_bits,
   input  logic             stat_rd,
   output logic [STAT_W-1:0] stat_byte,
   input  logic             cts_in_n,
   input  logic             dsr_in_n,
   input  logic             ri_in_n,
   input  logic             dcd_in_n,
   output logic             dtr_out_n,
   output logic             rts_out_n,
   output logic             out1_out_n,
   output logic             out2_out_n,
   input  logic             rx_near_full,
   output logic             tx_permit,
   output logic             irq_modem
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("modem_line_unit: SYNC_STAGES must be at least 2");
   end

   line_vec_t     pins_n, pins_sync_n, loop_src, cur, lines_q, delta_q;
   logic [LN-1:0] drv_n;

   always_comb begin
      pins_n          = '1;
      pins_n[IDX_CTS] = cts_in_n;
      pins_n[IDX_DSR] = dsr_in_n;
      pins_n[IDX_RI]  = ri_in_n;
      pins_n[IDX_DCD] = dcd_in_n;
   end

   mlu_sync #(.W(LN), .STAGES(SYNC_STAGES), .RST_VAL('1)) i_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d (pins_n),
      .q (pins_sync_n)
   );

   mlu_drive i_drive (
      .clk (clk),
      .rst_n (rst_n),
      .ctl (ctl_bits),
      .rx_near_full (rx_near_full),
      .drv_n (drv_n),
      .loop_src (loop_src)
   );

   assign cur = ctl_bits[CB_LOOP] ? loop_src : ~pins_sync_n;

   mlu_delta #(.RI_TRAIL_ONLY(RI_TRAIL_ONLY)) i_delta (
      .clk (clk),
      .rst_n (rst_n),
      .cur (cur),
      .clr (stat_rd),
      .lines_q (lines_q),
      .delta_q (delta_q)
   );

   assign stat_byte  = {lines_q, delta_q};
   assign irq_modem  = |delta_q;
   assign tx_permit  = ~ctl_bits[CB_AFC] | lines_q[IDX_CTS];
   assign dtr_out_n  = drv_n[DRV_DTR];
   assign rts_out_n  = drv_n[DRV_RTS];
   assign out1_out_n = drv_n[DRV_OUT1];
   assign out2_out_n = drv_n[DRV_OUT2];
endmodule

// File: rtl/mlu_chk.sv
module mlu_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [5:0] ctl_bits,
   input logic       stat_rd,
   input logic [7:0] stat_byte,
   input logic       dtr_out_n,
   input logic       rts_out_n,
   input logic       out1_out_n,
   input logic       out2_out_n,
   input logic       rx_near_full,
   input logic       tx_permit,
   input logic       irq_modem
);
   p_out_dtr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(ctl_bits[4])) |-> (dtr_out_n == !$past(ctl_bits[0])));

   p_ri_trail_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_byte[2]) |-> ($past(stat_byte[6]) && !stat_byte[6]));

   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_modem && !stat_rd) |=> irq_modem);

   p_loop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctl_bits[4]) |-> (dtr_out_n && rts_out_n && out1_out_n && out2_out_n));

   p_afc_rts_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctl_bits[5] && rx_near_full) |-> rts_out_n);

   p_permit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_bits[5] |-> tx_permit);
endmodule

bind modem_line_unit mlu_chk i_chk (
   .clk (clk),
   .rst_n (rst_n),
   .ctl_bits (ctl_bits),
   .stat_rd (stat_rd),
   .stat_byte (stat_byte),
   .dtr_out_n (dtr_out_n),
   .rts_out_n (rts_out_n),
   .out1_out_n (out1_out_n),
   .out2_out_n (out2_out_n),
   .rx_near_full (rx_near_full),
   .tx_permit (tx_permit),
   .irq_modem (irq_modem)
);

// File: tb/test_modem_line_unit.sv
module test_modem_line_unit;
   localparam int CLK_P  = 10;
   localparam int SYNC_P = 2;

   logic       clk = 0;
   logic       rst_n = 0;
   logic [5:0] ctl = 0;
   logic       rd = 0;
   logic       cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1, nf = 0;
   logic [7:0] stat;
   logic       dtr_o, rts_o, out1_o, out2_o, permit, irq;

   int n_chk = 0, n_fail = 0, cyc = 0;
   logic chk_on = 0;

   always #(CLK_P/2) clk = ~clk;

   modem_line_unit #(.SYNC_STAGES(SYNC_P)) i_modem_line_unit (
      .clk (clk), .rst_n (rst_n), .ctl_bits (ctl), .stat_rd (rd), .stat_byte (stat),
      .cts_in_n (cts_n), .dsr_in_n (dsr_n), .ri_in_n (ri_n), .dcd_in_n (dcd_n),
      .dtr_out_n (dtr_o), .rts_out_n (rts_o), .out1_out_n (out1_o), .out2_out_n (out2_o),
      .rx_near_full (nf), .tx_permit (permit), .irq_modem (irq)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // behavioural reference: levels, flags, pins and a queue of delayed pin samples
   logic [3:0] m_lines = 0, m_delta = 0, m_drv = 4'hF;
   logic [3:0] m_sync[$];

   always @(posedge clk) begin : model
      logic [3:0] cur, chg;
      logic       rts_e;
      cyc++;
      if (!rst_n) begin
         m_lines = 0; m_delta = 0; m_drv = 4'hF;
         m_sync.delete();
         for (int i = 0; i < SYNC_P; i++) m_sync.push_back(4'hF);
      end else begin
         rts_e = ctl[1] && !(ctl[5] && nf);
         if (ctl[4]) cur = {ctl[3], ctl[2], ctl[0], rts_e};
         else        cur = ~m_sync[SYNC_P-1];
         chg    = m_lines ^ cur;
         chg[2] = m_lines[2] && !cur[2];
         m_delta = (rd ? 4'h0 : m_delta) | chg;
         m_lines = cur;
         m_drv = ctl[4] ? 4'hF : ~{ctl[3], ctl[2], rts_e, ctl[0]};
         m_sync.push_front({dcd_n, ri_n, dsr_n, cts_n});
         void'(m_sync.pop_back());
      end
   end

   always @(negedge clk) begin
      if (chk_on) begin
         chk(stat[7:4] == m_lines, "R3", stat[7:4], m_lines);
         chk({stat[3], stat[1:0]} == {m_delta[3], m_delta[1:0]}, "R4",
             {stat[3], stat[1:0]}, {m_delta[3], m_delta[1:0]});
         chk(stat[2] == m_delta[2], "R5", stat[2], m_delta[2]);
         chk(irq == (m_delta != 0), "R7", irq, m_delta != 0);
         chk(permit == (!ctl[5] || m_lines[0]), "R10", permit, !ctl[5] || m_lines[0]);
         if (ctl[4])
            chk({out2_o, out1_o, rts_o, dtr_o} == m_drv, "R8", {out2_o, out1_o, rts_o, dtr_o}, m_drv);
         else if (ctl[5] && nf)
            chk({out2_o, out1_o, rts_o, dtr_o} == m_drv, "R9", {out2_o, out1_o, rts_o, dtr_o}, m_drv);
         else
            chk({out2_o, out1_o, rts_o, dtr_o} == m_drv, "R2", {out2_o, out1_o, rts_o, dtr_o}, m_drv);
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected below 150000", cyc);
         finish_run();
      end
   end

   initial begin
      tick(3);
      // R1 reset state
      chk(stat == 8'h00, "R1", stat, 0);
      chk({out2_o, out1_o, rts_o, dtr_o} == 4'hF, "R1", {out2_o, out1_o, rts_o, dtr_o}, 4'hF);
      chk(irq == 0 && permit == 1, "R1", {irq, permit}, 2'b01);
      rst_n = 1; chk_on = 1;
      tick(2);
      // R2 output drive patterns
      for (int i = 0; i < 16; i++) begin ctl = 6'(i); tick(2); end
      ctl = 6'h0;
      // R3/R4 pin changes
      cts_n = 0; tick(5); dsr_n = 0; tick(5); dcd_n = 0; tick(5);
      rd = 1; tick(1); rd = 0; tick(1);
      chk(stat[3:0] == 4'h0, "R6", stat[3:0], 0);
      // R5 ring: assert gives no flag, release gives flag
      ri_n = 0; tick(5);
      chk(stat[2] == 1'b0, "R5", stat[2], 0);
      ri_n = 1; tick(5);
      chk(stat[2] == 1'b1, "R5", stat[2], 1);
      rd = 1; tick(1); rd = 0; tick(1);
      // R6 change on the clearing edge keeps the flag
      cts_n = 1; tick(SYNC_P); rd = 1; tick(1); rd = 0;
      chk(stat[0] == 1'b1, "R6", stat[0], 1);
      rd = 1; tick(1); rd = 0; tick(1);
      chk(stat[0] == 1'b0, "R6", stat[0], 0);
      // R8 loopback with external pins wiggling
      for (int i = 0; i < 16; i++) begin
         ctl = 6'h10 | 6'(i);
         cts_n = ~cts_n; ri_n = ~ri_n;
         tick(2);
         if (i % 4 == 3) begin rd = 1; tick(1); rd = 0; end
      end
      // R9/R10 automatic flow control, in loopback and out
      ctl = 6'h32; nf = 0; tick(2); nf = 1; tick(2);
      chk(stat[4] == 1'b0, "R9", stat[4], 0);
      nf = 0; tick(2);
      chk(permit == 1'b1, "R10", permit, 1);
      ctl = 6'h22; cts_n = 1; tick(4); nf = 1; tick(2); cts_n = 0; tick(4); nf = 0; tick(2);
      cts_n = 1; tick(4);
      chk(permit == 1'b0, "R10", permit, 0);
      // mixed random traffic
      for (int i = 0; i < 4000; i++) begin
         ctl = 6'($urandom);
         if (($urandom % 4) == 0) ctl[4] = 0;
         cts_n = ($urandom % 5 == 0) ? ~cts_n : cts_n;
         dsr_n = ($urandom % 5 == 0) ? ~dsr_n : dsr_n;
         ri_n  = ($urandom % 5 == 0) ? ~ri_n  : ri_n;
         dcd_n = ($urandom % 5 == 0) ? ~dcd_n : dcd_n;
         nf = 1'($urandom);
         rd = ($urandom % 6 == 0);
         tick(1 + ($urandom % 3));
      end
      rd = 0; tick(2);
      finish_run();
   end
endmodule